// File: doc/BRIEF.md
# Glitch-Free Clock Stop and Power-Down Controller

This block sits between two free-running clock sources and the pins they drive: a modulated (spread) output clock and a reference clock. It gates each clock to stop and restart it. Every stop and start happens only while the source clock is low, so the pins never carry a shortened pulse. An active-low, asynchronous power-down pin stops both outputs and raises a power-down request toward the oscillator and PLL. When the pin is released, the outputs stay stopped for a programmable number of reference-clock cycles so that the PLL can settle.

Each output also has its own enable bit. Clearing it stops only that clock, drives the pin low and leaves the oscillator running. A stop-state select bit decides what a stopped pin does during power-down. With the bit at 0 the pin is released to high impedance (output enable low). With the bit at 1 the pin is held low (output enable high). Each clock domain synchronises every control it uses through its own two-flop stage.

Top module: `clk_pd_ctrl`

## Requirements
- R1: `pll_pd_o` follows the inverted `pwrdn_ni` through exactly two `ref_clk_i` rising edges. It is still unchanged at the falling edge after the first rising edge and has changed by the falling edge after the second.
- R2: While power-down is held, `mod_clk_o` and `ref_clk_o` stay low with no rising edges and `pll_pd_o` is 1.
- R3: Every high pulse on `mod_clk_o` or `ref_clk_o` is exactly as wide as the high phase of its source clock. This holds when the output stops and when it starts.
- R4: After power-down is released, neither output rises for at least `HOLD_CYCLES` reference cycles. Both resume within `HOLD_CYCLES`+10 reference cycles.
- R5: If power-down is asserted again during the hold-off, the count starts over. The outputs stay stopped until a full `HOLD_CYCLES` have passed after the last release.
- R6: During power-down, `stop_drive_low_i`=0 drives both output enables to 0 (high impedance) and `stop_drive_low_i`=1 drives them to 1 (driven low). Outside power-down, both output enables are 1.
- R7: `mod_en_i`=0 stops `mod_clk_o` low with its output enable at 1. `ref_clk_o` keeps running and `pll_pd_o` stays 0. Setting the bit back to 1 restarts the clock with no hold-off.
- R8: `ref_en_i`=0 stops `ref_clk_o` low with its output enable at 1. `mod_clk_o` keeps running and `pll_pd_o` stays 0. Setting the bit back to 1 restarts the clock.
- R9: While `rst_ni` is 0, both clock outputs are low, both output enables are 1 and `pll_pd_o` is 0. After reset is released, the `HOLD_CYCLES` hold-off applies before the first output pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous active-low reset |
| mod_clk_i | input | 1 | Modulated source clock |
| ref_clk_i | input | 1 | Reference source clock; also times the hold-off |
| pwrdn_ni | input | 1 | Asynchronous active-low power-down pin |
| mod_en_i | input | 1 | Enable bit for the modulated output |
| ref_en_i | input | 1 | Enable bit for the reference output |
| stop_drive_low_i | input | 1 | Stopped state in power-down: 0 high impedance, 1 driven low |
| mod_clk_o | output | 1 | Gated modulated clock |
| mod_oe_o | output | 1 | Output enable for the modulated pin |
| ref_clk_o | output | 1 | Gated reference clock |
| ref_oe_o | output | 1 | Output enable for the reference pin |
| pll_pd_o | output | 1 | Power-down request to the oscillator and PLL |

## Verification
The bench measures the width of every output pulse. A gate that switched while its source was high would show up as a runt pulse at a stop or a start. It counts reference cycles from each release of power-down to the first output edge on each clock. A design with a missing or short hold-off would resume too early. A design that kept its partial count when power-down was asserted again mid-interval would resume before a full interval had passed since the last release. It also checks the latency of the power-down request at single-cycle resolution, the output-enable level under both stop-state settings, and that disabling one output leaves the other output and the PLL request untouched.

// File: rtl/clk_pd_pkg.sv
package clk_pd_pkg;

  localparam int unsigned NUM_CLK     = 2;
  localparam int unsigned CLK_MOD     = 0;
  localparam int unsigned CLK_REF     = 1;
  localparam int unsigned SYNC_STAGES = 2;

  // controls carried into each clock domain
  typedef struct packed {
    logic pd;
    logic run;
    logic en;
    logic drive_low;
  } dom_ctl_t;

  localparam dom_ctl_t CTL_RESET = '{pd: 1'b0, run: 1'b0, en: 1'b0, drive_low: 1'b1};

endpackage

// File: rtl/clk_pd_sync.sv
module clk_pd_sync #(
  parameter int unsigned     WIDTH     = 1,
  parameter int unsigned     STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] q;
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= RESET_VAL;
        else         q <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= RESET_VAL;
        else         q <= g_stage[s-1].q;
      end
    end
  end

  assign q_o = g_stage[STAGES-1].q;

endmodule

// File: rtl/clk_pd_holdoff.sv
module clk_pd_holdoff
  import clk_pd_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 600000,
  localparam int unsigned CNT_W      = $clog2(HOLD_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwrdn_ni,
  output logic pd_req_o,
  output logic run_o
);

  logic             pd_q;
  logic             run_q;
  logic [CNT_W-1:0] cnt_q;

  clk_pd_sync #(
    .WIDTH    (1),
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(1'b0)
  ) u_pd_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (~pwrdn_ni),
    .q_o   (pd_q)
  );

  // count settle cycles after release; any power-down restarts the count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (pd_q) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (!run_q) begin
      if (cnt_q == CNT_W'(HOLD_CYCLES - 1)) run_q <= 1'b1;
      else                                  cnt_q <= cnt_q + 1'b1;
    end
  end

  assign pd_req_o = pd_q;
  assign run_o    = run_q;

  assert_pd_blocks_run_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_q |=> !run_q);

  assert_cnt_restart_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_q |=> (cnt_q == '0));

  assert_run_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !pd_q) |=> run_q);

  assert_full_interval_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_q) |-> ($past(cnt_q) == CNT_W'(HOLD_CYCLES - 1)));

endmodule

// File: rtl/clk_pd_gate.sv
module clk_pd_gate
  import clk_pd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwrdn_ni,
  input  logic run_i,
  input  logic en_i,
  input  logic drive_low_i,
  output logic clk_o,
  output logic oe_o
);

  dom_ctl_t ctl_raw;
  dom_ctl_t ctl_s;
  logic     req;
  logic     gate_q;

  assign ctl_raw = '{pd: ~pwrdn_ni, run: run_i, en: en_i, drive_low: drive_low_i};

  clk_pd_sync #(
    .WIDTH    ($bits(dom_ctl_t)),
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(CTL_RESET)
  ) u_ctl_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ctl_raw),
    .q_o   (ctl_s)
  );

  assign req = ctl_s.run & ctl_s.en & ~ctl_s.pd;

  // gate only moves while the source is low: no runt pulses
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= req;
  end

  assign clk_o = clk_i & gate_q;
  assign oe_o  = ~ctl_s.pd | ctl_s.drive_low;

  always @(gate_q) begin
    if (rst_ni) begin
      assert_gate_moves_low_R3: assert (clk_i == 1'b0)
        else $error("gate changed while source clock high");
    end
  end

  assert_stop_in_pd_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_s.pd |-> !gate_q);

  assert_hiz_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_o |-> !gate_q);

endmodule

// File: rtl/clk_pd_ctrl.sv
module clk_pd_ctrl
  import clk_pd_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 600000
) (
  input  logic rst_ni,
  input  logic mod_clk_i,
  input  logic ref_clk_i,
  input  logic pwrdn_ni,
  input  logic mod_en_i,
  input  logic ref_en_i,
  input  logic stop_drive_low_i,
  output logic mod_clk_o,
  output logic mod_oe_o,
  output logic ref_clk_o,
  output logic ref_oe_o,
  output logic pll_pd_o
);

  logic               run;
  logic [NUM_CLK-1:0] src_clk;
  logic [NUM_CLK-1:0] en_raw;
  logic [NUM_CLK-1:0] gclk;
  logic [NUM_CLK-1:0] oe;

  assign src_clk[CLK_MOD] = mod_clk_i;
  assign src_clk[CLK_REF] = ref_clk_i;
  assign en_raw[CLK_MOD]  = mod_en_i;
  assign en_raw[CLK_REF]  = ref_en_i;

  clk_pd_holdoff #(
    .HOLD_CYCLES(HOLD_CYCLES)
  ) u_holdoff (
    .clk_i   (ref_clk_i),
    .rst_ni  (rst_ni),
    .pwrdn_ni(pwrdn_ni),
    .pd_req_o(pll_pd_o),
    .run_o   (run)
  );

  for (genvar c = 0; c < NUM_CLK; c++) begin : g_out
    clk_pd_gate u_gate (
      .clk_i      (src_clk[c]),
      .rst_ni     (rst_ni),
      .pwrdn_ni   (pwrdn_ni),
      .run_i      (run),
      .en_i       (en_raw[c]),
      .drive_low_i(stop_drive_low_i),
      .clk_o      (gclk[c]),
      .oe_o       (oe[c])
    );
  end

  assign mod_clk_o = gclk[CLK_MOD];
  assign mod_oe_o  = oe[CLK_MOD];
  assign ref_clk_o = gclk[CLK_REF];
  assign ref_oe_o  = oe[CLK_REF];

endmodule

// File: tb/tb_clk_pd_ctrl.sv
`timescale 1ns/1ps
module tb_clk_pd_ctrl;

  localparam int  HOLD     = 40;
  localparam real REF_HALF = 2.5;
  localparam real MOD_HALF = 3.5;

  typedef struct {
    string tag;
    string req;
    bit    m_run;
    bit    r_run;
    bit    m_oe;
    bit    r_oe;
    bit    pd;
  } exp_t;

  logic rst_ni = 1'b0;
  logic mod_clk = 1'b0;
  logic ref_clk = 1'b0;
  logic pwrdn_n = 1'b1;
  logic mod_en = 1'b1;
  logic ref_en = 1'b1;
  logic drv_low = 1'b1;
  logic mod_clk_o, mod_oe_o, ref_clk_o, ref_oe_o, pll_pd_o;

  int checks = 0;
  int fails = 0;
  exp_t sb_q[$];
  int done_cnt = 0;
  int mod_edges = 0;
  int ref_edges = 0;
  int ref_cyc = 0;
  int first_ref = -1;
  int first_mod = -1;
  bit armed = 0;
  int mod_runts = 0, ref_runts = 0, mod_pulses = 0, ref_pulses = 0;
  realtime mod_rise_t = -1.0, ref_rise_t = -1.0;

  clk_pd_ctrl #(.HOLD_CYCLES(HOLD)) dut (
    .rst_ni          (rst_ni),
    .mod_clk_i       (mod_clk),
    .ref_clk_i       (ref_clk),
    .pwrdn_ni        (pwrdn_n),
    .mod_en_i        (mod_en),
    .ref_en_i        (ref_en),
    .stop_drive_low_i(drv_low),
    .mod_clk_o       (mod_clk_o),
    .mod_oe_o        (mod_oe_o),
    .ref_clk_o       (ref_clk_o),
    .ref_oe_o        (ref_oe_o),
    .pll_pd_o        (pll_pd_o)
  );

  initial forever #(REF_HALF) ref_clk = ~ref_clk;
  initial forever #(MOD_HALF) mod_clk = ~mod_clk;

  always @(negedge ref_clk) ref_cyc++;

  always @(posedge mod_clk_o) begin
    mod_edges++;
    mod_rise_t = $realtime;
    if (armed && first_mod < 0) first_mod = ref_cyc;
  end
  always @(posedge ref_clk_o) begin
    ref_edges++;
    ref_rise_t = $realtime;
    if (armed && first_ref < 0) first_ref = ref_cyc;
  end

  // R3: pulse width equals source high phase
  always @(negedge mod_clk_o) if (mod_rise_t >= 0.0) begin
    mod_pulses++;
    if (($realtime - mod_rise_t) < MOD_HALF - 0.01 || ($realtime - mod_rise_t) > MOD_HALF + 0.01) begin
      mod_runts++;
      $display("FAIL R3 mod pulse width actual=%0t expected=%0t", $realtime - mod_rise_t, MOD_HALF);
    end
  end
  always @(negedge ref_clk_o) if (ref_rise_t >= 0.0) begin
    ref_pulses++;
    if (($realtime - ref_rise_t) < REF_HALF - 0.01 || ($realtime - ref_rise_t) > REF_HALF + 0.01) begin
      ref_runts++;
      $display("FAIL R3 ref pulse width actual=%0t expected=%0t", $realtime - ref_rise_t, REF_HALF);
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive(bit pd_n, bit me, bit re, bit dl);
    @(negedge ref_clk);
    #0.7;
    pwrdn_n = pd_n;
    mod_en  = me;
    ref_en  = re;
    drv_low = dl;
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge ref_clk);
  endtask

  // driver side of the scoreboard
  task automatic expect_state(string tag, string req, bit m_run, bit r_run, bit m_oe, bit r_oe, bit pd);
    exp_t it;
    int prev;
    it.tag = tag; it.req = req;
    it.m_run = m_run; it.r_run = r_run; it.m_oe = m_oe; it.r_oe = r_oe; it.pd = pd;
    prev = done_cnt;
    sb_q.push_back(it);
    wait (done_cnt == prev + 1);
  endtask

  // monitor side: observe a window, compare with popped expectation
  initial begin
    forever begin
      exp_t it;
      int m0, r0, dm, dr;
      wait (sb_q.size() != 0);
      it = sb_q.pop_front();
      m0 = mod_edges;
      r0 = ref_edges;
      repeat (10) @(negedge ref_clk);
      dm = mod_edges - m0;
      dr = ref_edges - r0;
      check(it.m_run ? (dm > 0) : (dm == 0), it.req, {it.tag, " mod edges"}, dm, it.m_run ? 1 : 0);
      check(it.r_run ? (dr > 0) : (dr == 0), it.req, {it.tag, " ref edges"}, dr, it.r_run ? 1 : 0);
      check(mod_oe_o == it.m_oe, it.req, {it.tag, " mod_oe_o"}, int'(mod_oe_o), int'(it.m_oe));
      check(ref_oe_o == it.r_oe, it.req, {it.tag, " ref_oe_o"}, int'(ref_oe_o), int'(it.r_oe));
      check(pll_pd_o == it.pd, it.req, {it.tag, " pll_pd_o"}, int'(pll_pd_o), int'(it.pd));
      if (!it.m_run) check(mod_clk_o == 1'b0, it.req, {it.tag, " mod level"}, int'(mod_clk_o), 0);
      if (!it.r_run) check(ref_clk_o == 1'b0, it.req, {it.tag, " ref level"}, int'(ref_clk_o), 0);
      done_cnt++;
    end
  end

  // first output edge of each clock relative to a release at base
  task automatic measure_start(string req, int base, int lo, int hi);
    int dr, dm;
    while ((first_ref < 0 || first_mod < 0) && (ref_cyc - base) < hi + 6) @(negedge ref_clk);
    armed = 0;
    dr = (first_ref < 0) ? -1 : first_ref - base;
    dm = (first_mod < 0) ? -1 : first_mod - base;
    check(dr >= lo && dr <= hi, req, "ref start delay", dr, lo);
    check(dm >= lo && dm <= hi, req, "mod start delay", dm, lo);
  endtask

  task automatic arm(output int base);
    first_ref = -1;
    first_mod = -1;
    armed = 1;
    base = ref_cyc;
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int base;
    // R9 reset state
    settle(4);
    check(mod_clk_o == 1'b0, "R9", "mod_clk_o in reset", int'(mod_clk_o), 0);
    check(ref_clk_o == 1'b0, "R9", "ref_clk_o in reset", int'(ref_clk_o), 0);
    check(mod_oe_o == 1'b1, "R9", "mod_oe_o in reset", int'(mod_oe_o), 1);
    check(ref_oe_o == 1'b1, "R9", "ref_oe_o in reset", int'(ref_oe_o), 1);
    check(pll_pd_o == 1'b0, "R9", "pll_pd_o in reset", int'(pll_pd_o), 0);
    @(negedge ref_clk);
    #0.7;
    arm(base);
    rst_ni = 1'b1;
    measure_start("R9", base, HOLD, HOLD + 10);

    expect_state("running", "R7", 1, 1, 1, 1, 0);

    // R7 modulated enable
    drive(1, 0, 1, 1);
    settle(12);
    expect_state("mod disabled", "R7", 0, 1, 1, 1, 0);
    drive(1, 1, 1, 1);
    settle(12);
    expect_state("mod re-enabled", "R7", 1, 1, 1, 1, 0);

    // R8 reference enable
    drive(1, 1, 0, 1);
    settle(12);
    expect_state("ref disabled", "R8", 1, 0, 1, 1, 0);
    drive(1, 1, 1, 1);
    settle(12);
    expect_state("ref re-enabled", "R8", 1, 1, 1, 1, 0);

    // R1 request latency on entry
    drive(0, 1, 1, 1);
    @(negedge ref_clk);
    check(pll_pd_o == 1'b0, "R1", "pll_pd_o after one edge", int'(pll_pd_o), 0);
    @(negedge ref_clk);
    check(pll_pd_o == 1'b1, "R1", "pll_pd_o after two edges", int'(pll_pd_o), 1);
    settle(12);
    expect_state("pd drive low", "R2", 0, 0, 1, 1, 1);

    drive(0, 1, 1, 0);
    settle(12);
    expect_state("pd hi-z", "R6", 0, 0, 0, 0, 1);

    // R4 release with hold-off; R1 latency on exit
    drive(1, 1, 1, 0);
    arm(base);
    @(negedge ref_clk);
    check(pll_pd_o == 1'b1, "R1", "pll_pd_o one edge after release", int'(pll_pd_o), 1);
    @(negedge ref_clk);
    check(pll_pd_o == 1'b0, "R1", "pll_pd_o two edges after release", int'(pll_pd_o), 0);
    measure_start("R4", base, HOLD, HOLD + 10);
    expect_state("after hold-off", "R6", 1, 1, 1, 1, 0);

    // R5 re-assert inside hold-off
    drive(0, 1, 1, 1);
    settle(12);
    drive(1, 1, 1, 1);
    arm(base);
    settle(20);
    drive(0, 1, 1, 1);
    settle(4);
    drive(1, 1, 1, 1);
    measure_start("R5", base, HOLD + 24, HOLD + 40);
    expect_state("after restarted hold-off", "R5", 1, 1, 1, 1, 0);

    // R3 pulse integrity summary
    check(mod_runts == 0 && mod_pulses > 0, "R3", "mod runt pulses", mod_runts, 0);
    check(ref_runts == 0 && ref_pulses > 0, "R3", "ref runt pulses", ref_runts, 0);

    finish_run();
  end

endmodule